// File: doc/BRIEF.md
# Framed PCM Serial Port

This block connects one voice channel to a PCM highway. For transmit, a producer hands over an 8-bit code word on a valid/ready input. A rising edge of the transmit frame strobe moves that word into a shift register. The word then leaves MSB first, one bit per rising edge of the transmit shift clock. An output-enable marks the eight bit slots. Outside those slots the line is treated as high-impedance.

For receive, a separate frame strobe and a separate shift clock are used. Bits are gathered on falling shift-clock edges into a parallel word. That word is presented with a one-cycle valid pulse. Both directions count bits with their own counters, and each counter restarts on its strobe's rising edge, so the strobe width has no effect. A watchdog clocked by the system clock declares power-down when neither strobe has risen for too long. An active-low power-down pin forces the same state.

All strobe and shift-clock inputs must be synchronous to `clk` and must hold each level for at least one `clk` cycle. Edges are found by comparing each input with its value on the previous cycle. Back-pressure rules:
- The transmit input accepts a word when `tx_valid` and `tx_ready` are both high at a clock edge.
- `tx_ready` stays low from that edge until a strobe consumes the word.
- The receive output has no ready signal, because the highway cannot be stalled. A consumer must take `rx_word` in the cycle where `rx_valid` is high.

Top module: `pcm_serial_port`

## Requirements
- R1: After reset, `tx_oe` and `rx_valid` are 0, `tx_ready` is 1, and `power_down` equals the inverse of `pd_n`.
- R2: `tx_ready` is high exactly when the one-word holding register is empty. A word offered while `tx_ready` is high is accepted at that edge. `tx_ready` then stays low until a transmit strobe rising edge takes the word; words offered meanwhile are dropped.
- R3: A transmit strobe rising edge (with `pd_n` high) loads the held word, or IDLE_WORD (default 8'hFF) if the register is empty. It also restarts the bit count, even in the middle of a frame.
- R4: After a transmit strobe rising edge, the first 8 rising edges of `tx_sclk` each present one bit on `tx_data`, MSB (bit 7) first. `tx_oe` is high from the 1st to the 9th such edge.
- R5: `tx_oe` goes low on the 9th `tx_sclk` rising edge after the strobe. Further rising edges do nothing until the next strobe, whatever the strobe width.
- R6: After a receive strobe rising edge, `rx_data` is sampled on each of the next 8 falling edges of `rx_sclk`, first bit into bit 7. One cycle after the 8th sample, `rx_word` holds the byte and `rx_valid` is high for exactly one cycle.
- R7: Falling edges of `rx_sclk` after the 8th, and any before the first receive strobe, do not change `rx_word` or raise `rx_valid`.
- R8: If neither strobe rises for more than LOSS_LIMIT consecutive cycles, `power_down` goes high. It stays high until the next rising edge of either strobe, which clears it in the same cycle that strobe is seen.
- R9: While `pd_n` is low, `power_down` is high, `tx_oe` is forced low one cycle later, and frames in progress are abandoned. No strobe starts a frame and `rx_valid` is not raised.
- R10: The transmit and receive paths are independent: a strobe on one side starts no frame on the other side.
- R11: When a strobe rising edge and a shift-clock edge of the same direction fall in the same cycle, the strobe wins and the shift edge is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Active-low power-down request |
| tx_word | input | WORD_W | Code word offered for transmission |
| tx_valid | input | 1 | `tx_word` is valid |
| tx_ready | output | 1 | Holding register empty; the word will be accepted |
| tx_strobe | input | 1 | Transmit frame strobe; rising edge starts a frame |
| tx_sclk | input | 1 | Transmit shift clock |
| tx_data | output | 1 | Serial transmit bit, meaningful while `tx_oe` is high |
| tx_oe | output | 1 | Output enable; low means the line is released |
| rx_strobe | input | 1 | Receive frame strobe; rising edge starts a frame |
| rx_sclk | input | 1 | Receive shift clock |
| rx_data | input | 1 | Serial receive bit |
| rx_word | output | WORD_W | Last complete received word |
| rx_valid | output | 1 | One-cycle pulse when `rx_word` is new |
| power_down | output | 1 | High when `pd_n` is low or strobes have been lost |

## Verification
The properties assume the following about the inputs:
- Every strobe and shift-clock level lasts at least one `clk` cycle and changes only between clock edges.
- The producer does not rely on `tx_valid` while `tx_ready` is low.

The bench changes all inputs on the falling edge of `clk`. It holds each shift-clock level for one full cycle and leaves gaps between frames that are well below LOSS_LIMIT, except in the deliberate strobe-loss phase. The properties make no assumption about strobe width, so the stimulus varies it from one cycle up to longer than a whole frame.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
  // Positions of the sampled timing pins inside the edge-detector vector.
  localparam int PIN_CNT  = 4;
  localparam int P_TX_STB = 0;
  localparam int P_TX_CLK = 1;
  localparam int P_RX_STB = 2;
  localparam int P_RX_CLK = 3;
  // Receive data is taken on falling shift-clock edges; all others are rising.
  localparam logic [PIN_CNT-1:0] FALL_MASK = 4'b1000;
endpackage

// File: rtl/pcm_edge_detect.sv
module pcm_edge_detect #(
  parameter int N = 4,
  parameter logic [N-1:0] FALLING = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sig,
  output logic [N-1:0] hit
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sig;
  end

  for (genvar i = 0; i < N; i++) begin : g_pin
    if (FALLING[i]) begin : g_fall
      assign hit[i] = prev_q[i] & ~sig[i];
    end else begin : g_rise
      assign hit[i] = sig[i] & ~prev_q[i];
    end
  end
endmodule

// File: rtl/pcm_strobe_watch.sv
module pcm_strobe_watch #(
  parameter int LIMIT = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic seen,
  output logic lost
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] idle_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= '0;
      lost   <= 1'b0;
    end else if (seen) begin
      idle_q <= '0;
      lost   <= 1'b0;
    end else if (idle_q == CW'(LIMIT)) begin
      lost   <= 1'b1;
    end else begin
      idle_q <= idle_q + 1'b1;
    end
  end
endmodule

// File: rtl/pcm_tx_serializer.sv
module pcm_tx_serializer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         halt,
  input  logic         shift,
  input  logic [W-1:0] word,
  output logic         data,
  output logic         oe
);
  localparam int LW = $clog2(W + 2);
  logic [W-1:0]  sh_q;
  logic [LW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
      data   <= 1'b0;
      oe     <= 1'b0;
    end else if (start) begin
      sh_q   <= word;
      left_q <= LW'(W + 1);
      oe     <= 1'b0;
    end else if (halt) begin
      left_q <= '0;
      oe     <= 1'b0;
    end else if (shift && left_q != '0) begin
      left_q <= left_q - 1'b1;
      if (left_q == LW'(1)) begin
        oe <= 1'b0;
      end else begin
        oe   <= 1'b1;
        data <= sh_q[W-1];
        sh_q <= {sh_q[W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/pcm_rx_deserializer.sv
module pcm_rx_deserializer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         halt,
  input  logic         sample,
  input  logic         din,
  output logic [W-1:0] word,
  output logic         valid
);
  localparam int CW = $clog2(W);
  logic [W-1:0]  sh_q;
  logic [CW-1:0] cnt_q;
  logic          act_q;
  logic [W-1:0]  nxt;

  assign nxt = {sh_q[W-2:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      act_q <= 1'b0;
      word  <= '0;
      valid <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (start) begin
        act_q <= 1'b1;
        cnt_q <= '0;
      end else if (halt) begin
        act_q <= 1'b0;
        cnt_q <= '0;
      end else if (sample && act_q) begin
        sh_q <= nxt;
        if (cnt_q == CW'(W - 1)) begin
          word  <= nxt;
          valid <= 1'b1;
          act_q <= 1'b0;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port #(
  parameter int            WORD_W     = 8,
  parameter int            LOSS_LIMIT = 50000,
  parameter logic [WORD_W-1:0] IDLE_WORD = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pd_n,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic              tx_strobe,
  input  logic              tx_sclk,
  output logic              tx_data,
  output logic              tx_oe,
  input  logic              rx_strobe,
  input  logic              rx_sclk,
  input  logic              rx_data,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_valid,
  output logic              power_down
);
  import pcm_pkg::*;

  logic [PIN_CNT-1:0] pins, hit;
  logic               lost;
  logic               tx_go, rx_go, halt;
  logic               hold_full_q;
  logic [WORD_W-1:0]  hold_q;
  logic [WORD_W-1:0]  load_word;

  always_comb begin
    pins           = '0;
    pins[P_TX_STB] = tx_strobe;
    pins[P_TX_CLK] = tx_sclk;
    pins[P_RX_STB] = rx_strobe;
    pins[P_RX_CLK] = rx_sclk;
  end

  pcm_edge_detect #(.N(PIN_CNT), .FALLING(FALL_MASK)) u_edges (
    .clk(clk), .rst_n(rst_n), .sig(pins), .hit(hit)
  );

  pcm_strobe_watch #(.LIMIT(LOSS_LIMIT)) u_watch (
    .clk(clk), .rst_n(rst_n),
    .seen(hit[P_TX_STB] | hit[P_RX_STB]),
    .lost(lost)
  );

  assign power_down = ~pd_n | lost;
  assign halt       = ~pd_n | lost;
  assign tx_go      = pd_n & hit[P_TX_STB];
  assign rx_go      = pd_n & hit[P_RX_STB];

  // One-word holding register on the stream input.
  assign tx_ready  = ~hold_full_q;
  assign load_word = hold_full_q ? hold_q : IDLE_WORD;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full_q <= 1'b0;
      hold_q      <= '0;
    end else if (tx_valid && !hold_full_q) begin
      hold_full_q <= 1'b1;
      hold_q      <= tx_word;
    end else if (tx_go) begin
      hold_full_q <= 1'b0;
    end
  end

  pcm_tx_serializer #(.W(WORD_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .start(tx_go), .halt(halt),
    .shift(hit[P_TX_CLK]), .word(load_word),
    .data(tx_data), .oe(tx_oe)
  );

  pcm_rx_deserializer #(.W(WORD_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .start(rx_go), .halt(halt),
    .sample(hit[P_RX_CLK]), .din(rx_data),
    .word(rx_word), .valid(rx_valid)
  );
endmodule

// File: rtl/pcm_serial_port_chk.sv
module pcm_serial_port_chk (
  input logic clk,
  input logic rst_n,
  input logic pd_n,
  input logic tx_valid,
  input logic tx_ready,
  input logic tx_strobe,
  input logic tx_sclk,
  input logic tx_oe,
  input logic rx_sclk,
  input logic rx_valid,
  input logic power_down
);
  // R2
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_ready) |-> $past(tx_valid));
  // R4
  oe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_oe) |-> $past(tx_sclk));
  // R5
  oe_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_oe) |-> ($past(tx_sclk) || $past(tx_strobe) || !$past(pd_n) || $past(power_down)));
  // R6
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R6
  rx_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !$past(rx_sclk));
  // R9
  pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |=> !tx_oe);
endmodule

bind pcm_serial_port pcm_serial_port_chk u_chk (.*);

// File: tb/pcm_serial_port_tb.sv
module pcm_serial_port_tb;
  localparam int LIM = 200;

  logic clk = 0, rst_n = 0, pd_n = 1;
  logic [7:0] tx_word = 0;
  logic tx_valid = 0, tx_strobe = 0, tx_sclk = 0;
  logic rx_strobe = 0, rx_sclk = 0, rx_data = 0;
  logic tx_ready, tx_data, tx_oe, rx_valid, power_down;
  logic [7:0] rx_word;

  int checks = 0, fails = 0, rx_seen = 0;
  logic [7:0] last_rx = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pcm_serial_port #(.WORD_W(8), .LOSS_LIMIT(LIM)) u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model, updated at each rising edge.
  logic [7:0] q[$];
  bit p_ts, p_tc, p_rs, p_rc, m_lost, m_oe, m_data, m_rv, rx_act;
  int m_idle, tx_left, rx_n;
  logic [7:0] frame, rsh, m_rw;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); p_ts = 0; p_tc = 0; p_rs = 0; p_rc = 0;
      m_lost = 0; m_idle = 0; m_oe = 0; m_data = 0; m_rv = 0;
      rx_act = 0; tx_left = 0; rx_n = 0; frame = 0; rsh = 0; m_rw = 0;
    end else begin
      bit ts_r, tc_r, rs_r, rc_f, lost_old, rdy_old;
      ts_r = tx_strobe && !p_ts; tc_r = tx_sclk && !p_tc;
      rs_r = rx_strobe && !p_rs; rc_f = !rx_sclk && p_rc;
      lost_old = m_lost; rdy_old = (q.size() == 0);
      if (ts_r || rs_r) begin m_idle = 0; m_lost = 0; end
      else if (m_idle == LIM) m_lost = 1;
      else m_idle++;
      if (!pd_n) begin tx_left = 0; m_oe = 0; end
      else if (ts_r) begin
        frame = (q.size() != 0) ? q.pop_front() : 8'hFF;
        tx_left = 9; m_oe = 0;
      end else if (lost_old) begin tx_left = 0; m_oe = 0; end
      else if (tc_r && tx_left > 0) begin
        if (tx_left == 1) m_oe = 0;
        else begin m_oe = 1; m_data = frame[tx_left-2]; end
        tx_left--;
      end
      if (tx_valid && rdy_old) q.push_back(tx_word);
      m_rv = 0;
      if (!pd_n) rx_act = 0;
      else if (rs_r) begin rx_act = 1; rx_n = 0; end
      else if (lost_old) rx_act = 0;
      else if (rc_f && rx_act) begin
        rsh = {rsh[6:0], rx_data}; rx_n++;
        if (rx_n == 8) begin m_rv = 1; m_rw = rsh; rx_act = 0; end
      end
      p_ts = tx_strobe; p_tc = tx_sclk; p_rs = rx_strobe; p_rc = rx_sclk;
      #1;
      chk("R5 tx_oe", tx_oe, m_oe);
      if (m_oe) chk("R4 tx_data", tx_data, m_data);
      chk("R6 rx_valid", rx_valid, m_rv);
      if (m_rv) chk("R6 rx_word", rx_word, m_rw);
      chk("R8 power_down", power_down, !pd_n || m_lost);
      chk("R2 tx_ready", tx_ready, q.size() == 0);
      if (rx_valid) begin rx_seen++; last_rx = rx_word; end
    end
  end

  task automatic push(input logic [7:0] w);
    @(negedge clk); tx_valid = 1; tx_word = w;
    @(negedge clk); tx_valid = 0;
  endtask

  task automatic frame_run(input bit dtx, input bit drx, input logic [7:0] rxb,
                           input int pulses, input int sw,
                           output logic [7:0] got, output int oe_hi);
    int cyc;
    got = 0; oe_hi = 0; cyc = 0;
    @(negedge clk); if (dtx) tx_strobe = 1; if (drx) rx_strobe = 1;
    for (int i = 0; i < pulses; i++) begin
      @(negedge clk); cyc++;
      if (cyc >= sw) begin tx_strobe = 0; rx_strobe = 0; end
      tx_sclk = 1; rx_sclk = 1; rx_data = (i < 8) ? rxb[7-i] : 1'b1;
      @(posedge clk); #1;
      if (tx_oe) begin oe_hi++; if (i < 8) got[7-i] = tx_data; end
      @(negedge clk); cyc++;
      if (cyc >= sw) begin tx_strobe = 0; rx_strobe = 0; end
      tx_sclk = 0; rx_sclk = 0;
    end
    repeat (3) @(negedge clk);
    tx_strobe = 0; rx_strobe = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] got; int oe_hi, n0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(posedge clk); #1;
    chk("R1 tx_oe", tx_oe, 0); chk("R1 rx_valid", rx_valid, 0);
    chk("R1 tx_ready", tx_ready, 1); chk("R1 power_down", power_down, 0);

    // R7: receive clocks before any strobe
    frame_run(0, 0, 8'h00, 8, 1, got, oe_hi);
    chk("R7 no strobe rx", rx_seen, 0);

    // basic frame
    push(8'hA5);
    chk("R2 ready low after accept", tx_ready, 0);
    push(8'h11);  // dropped: register full
    frame_run(1, 1, 8'h3C, 8, 1, got, oe_hi);
    chk("R4 tx byte", got, 8'hA5); chk("R4 oe slots", oe_hi, 8);
    chk("R6 rx byte", last_rx, 8'h3C); chk("R6 rx count", rx_seen, 1);
    chk("R2 ready after strobe", tx_ready, 1);

    // R3: empty holding register sends idle word
    frame_run(1, 0, 8'h00, 8, 1, got, oe_hi);
    chk("R3 idle word", got, 8'hFF);
    chk("R10 tx-only no rx", rx_seen, 1);

    // R5/R7: extra shift edges and a wide strobe
    push(8'h5A);
    frame_run(1, 1, 8'hC3, 11, 25, got, oe_hi);
    chk("R5 tx byte wide strobe", got, 8'h5A); chk("R5 extra edges", oe_hi, 8);
    chk("R7 rx extra edges", last_rx, 8'hC3); chk("R7 rx single", rx_seen, 2);

    // R3: restart mid-frame
    push(8'h12);
    frame_run(1, 0, 8'h00, 4, 1, got, oe_hi);
    chk("R3 partial", got[7:4], 4'h1);
    push(8'h9C);
    frame_run(1, 0, 8'h00, 8, 1, got, oe_hi);
    chk("R3 restart byte", got, 8'h9C);

    // R10: receive-only frame leaves transmit idle
    frame_run(0, 1, 8'h81, 8, 2, got, oe_hi);
    chk("R10 rx-only no oe", oe_hi, 0); chk("R10 rx byte", last_rx, 8'h81);

    // R11: strobe and shift edge in the same cycle
    push(8'h6B);
    @(negedge clk); tx_strobe = 1; tx_sclk = 1;
    @(negedge clk); tx_strobe = 0; tx_sclk = 0;
    frame_run(0, 0, 8'h00, 9, 1, got, oe_hi);
    chk("R11 coincident edge", got, 8'h6B); chk("R11 slots", oe_hi, 8);

    // R9: power-down pin
    @(negedge clk); pd_n = 0;
    @(posedge clk); #1; chk("R9 power_down", power_down, 1);
    n0 = rx_seen;
    frame_run(1, 1, 8'h44, 8, 1, got, oe_hi);
    chk("R9 no tx", oe_hi, 0); chk("R9 no rx", rx_seen, n0);
    @(negedge clk); pd_n = 1;

    // R8: strobe loss and recovery
    frame_run(0, 1, 8'h27, 8, 1, got, oe_hi);
    chk("R8 alive", power_down, 0);
    repeat (LIM + 10) @(negedge clk);
    chk("R8 lost", power_down, 1);
    frame_run(0, 1, 8'hE4, 8, 1, got, oe_hi);
    chk("R8 recovered", power_down, 0); chk("R8 rx after loss", last_rx, 8'hE4);

    repeat (5) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule